// File: doc/BRIEF.md
# TDM bus clock and frame generator

This block produces the timing set for a time-division-multiplexed backplane from a stream of master-clock ticks that an upstream phase corrector has already adjusted. Every two master ticks it advances one half period of a 4.096 MHz bus clock. That gives a 4.096 MHz clock and its inverse, a pair of 2.048 MHz clocks of opposite polarity, and an active-low 8 kHz frame pulse. All of these are placed so that the clock edges sitting inside the frame-pulse window have fixed polarities.

A source-select input can set the master ticks aside. The half-period steps are then taken from the edges of an external 4.096 MHz clock, which passes through a synchronizer first. A direction input turns the frame pulse into an input. When the external clock source and the input direction are both selected, a low external frame pulse seen on a falling external clock edge moves the frame back to its start phase. Output-enable inputs control the inverted 4.096 MHz line and the pair of 2.048 MHz lines. Each tri-state is modelled as an enable flag, and a disabled line is also driven low.

Top module: `tdm_clkgen`

## Requirements
- R1: While reset is held, and right after it is released, the frame position is at frame start: c4=0, c2_a=0, c2_b=1, c4_n=1 (when enabled) and fp_n=0.
- R2: With int_src=1, the frame position advances one half period of the 4.096 MHz clock on every second master_tick, counted from reset. c4 equals bit 0 of that position, so one c4 period takes four ticks.
- R3: c2_a equals bit 1 of the half-period position and c2_b is its inverse, so each has half the frequency of c4.
- R4: A frame is 1024 half periods (512 c4 periods). fp_n is low at the last position (1023) and at position 0, which is one c4 period, and high everywhere else.
- R5: At the step from 1023 to 0, which lies inside the frame-pulse window, c4 and c2_a fall while c4_n and c2_b rise.
- R6: With int_src=0, master_tick has no effect. Each edge of ext_clk4 advances the position by one, and the output changes on the third clk edge after ext_clk4 changes.
- R7: fp_oe equals fp_dir_out: 1 means the frame pulse is an output, 0 means it is an input.
- R8: With int_src=0 and fp_dir_out=0, a low ext_fp_n on a falling ext_clk4 edge sets the position to 0 (frame start). A low ext_fp_n on a rising edge does nothing.
- R9: With int_src=1, or with fp_dir_out=1, ext_fp_n has no effect on the frame position.
- R10: c4_n_en follows en_c4 and c2_en follows en_c2. A disabled line is driven 0. c4 is never gated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than all tick and external clock rates |
| rst_n | input | 1 | Synchronous active-low reset |
| master_tick | input | 1 | One-cycle strobe per corrected master-clock period |
| int_src | input | 1 | 1: step on master ticks; 0: step on ext_clk4 edges |
| fp_dir_out | input | 1 | 1: frame pulse is an output; 0: frame pulse is an input |
| ext_clk4 | input | 1 | External 4.096 MHz clock level, asynchronous |
| ext_fp_n | input | 1 | External active-low frame pulse, asynchronous |
| en_c4 | input | 1 | Enable for the inverted 4.096 MHz line |
| en_c2 | input | 1 | Enable for both 2.048 MHz lines |
| c4 | output | 1 | 4.096 MHz clock, falls inside the frame window |
| c4_n | output | 1 | Inverted 4.096 MHz clock, gated by en_c4 |
| c4_n_en | output | 1 | Drive flag for c4_n |
| c2_a | output | 1 | 2.048 MHz clock, falls inside the frame window |
| c2_b | output | 1 | 2.048 MHz clock, rises inside the frame window |
| c2_en | output | 1 | Drive flag for c2_a and c2_b |
| fp_n | output | 1 | Active-low 8 kHz frame pulse |
| fp_oe | output | 1 | Drive flag for fp_n |

## Verification
A falling external clock edge can carry both the step from 1023 to 0 and an alignment request at the same time. Both must land on position 0 without either the wrap or the alignment being lost. The bench provokes this by raising the external frame pulse exactly when its model stands at 1023 ahead of a falling edge. Elsewhere it raises the pulse mid-frame and on rising edges, and checks that only the falling-edge case moves the frame. The bench also toggles master_tick while the external clock is selected, and toggles ext_clk4 and ext_fp_n while master ticks are selected. In each case every output is compared with the bench's own position model, which shows that the unselected source is ignored in the same cycles in which the selected one steps.

// File: rtl/tdm_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the TDM clock and frame generator.
// Assumes nothing beyond being compiled ahead of the modules that use it.
package tdm_pkg;

    // Timing lines produced from one frame position (values before tri-state flags).
    typedef struct packed {
        logic c4;
        logic c4_n;
        logic c2_a;
        logic c2_b;
        logic fp_n;
    } tdm_lines_t;

    // Smallest width able to index 0..n-1 (at least one bit).
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tdm_edge_src.sv
`timescale 1ns/1ps
// Module: tdm_edge_src
// Produces a one-cycle step strobe for each half period of the 4.096 MHz bus clock.
// Internal source: divides master ticks by TICKS_PER_HALF. External source: detects
// edges of ext_clk4 after a SYNC_STAGES-deep synchronizer. The external frame pulse
// goes through a chain of the same depth, so it lines up with the clock edges.
// Assumes SYNC_STAGES >= 2 and that clk is faster than any ext_clk4 edge rate.
module tdm_edge_src #(
    parameter int TICKS_PER_HALF = 2,
    parameter int SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic int_src,
    input  logic master_tick,
    input  logic ext_clk4,
    input  logic ext_fp_n,
    output logic step,
    output logic step_fall,
    output logic fp_seen
);
    logic                   int_step;
    logic [SYNC_STAGES-1:0] ck_sync;
    logic [SYNC_STAGES-1:0] fp_sync;
    logic                   ck_prev;
    logic                   ext_step;
    logic                   ext_fall;

    generate
        if (TICKS_PER_HALF > 1) begin : g_div
            localparam int TW = tdm_pkg::idx_width(TICKS_PER_HALF);
            localparam logic [TW-1:0] TC_LAST = TW'(TICKS_PER_HALF - 1);
            logic [TW-1:0] tcnt;

            // Count master ticks within one half period.
            always_ff @(posedge clk) begin
                if (!rst_n)                    tcnt <= '0;
                else if (int_src && master_tick) tcnt <= (tcnt == TC_LAST) ? '0 : tcnt + 1'b1;
            end

            assign int_step = master_tick && (tcnt == TC_LAST);

            // R2: internal steps are spaced by at least two cycles.
            assert_step_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (int_src && step) |=> (!step || !int_src));
        end else begin : g_nodiv
            assign int_step = master_tick;
        end
    endgenerate

    // Synchronize the external clock and frame pulse through equal-depth chains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_sync <= '0;
            fp_sync <= '1;
            ck_prev <= 1'b0;
        end else begin
            ck_sync <= {ck_sync[SYNC_STAGES-2:0], ext_clk4};
            fp_sync <= {fp_sync[SYNC_STAGES-2:0], ext_fp_n};
            ck_prev <= ck_sync[SYNC_STAGES-1];
        end
    end

    // Edge detection on the synchronized external clock.
    always_comb begin
        ext_step = ck_sync[SYNC_STAGES-1] ^ ck_prev;
        ext_fall = ck_prev & ~ck_sync[SYNC_STAGES-1];
    end

    // Select the step source.
    always_comb begin
        step      = int_src ? int_step : ext_step;
        step_fall = !int_src && ext_fall;
        fp_seen   = !fp_sync[SYNC_STAGES-1];
    end
endmodule

// File: rtl/tdm_frame_ctr.sv
`timescale 1ns/1ps
// Module: tdm_frame_ctr
// Holds the position within the frame in half periods of the 4.096 MHz clock.
// It wraps after HALVES_PER_FRAME steps, and an alignment request returns it to 0.
// Assumes an alignment request only ever arrives together with a step.
module tdm_frame_ctr #(
    parameter int HALVES_PER_FRAME = 1024,
    parameter int CW               = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          step_fall,
    input  logic          fp_seen,
    input  logic          align_en,
    output logic [CW-1:0] pos
);
    localparam logic [CW-1:0] POS_LAST = CW'(HALVES_PER_FRAME - 1);

    logic align;

    // Alignment happens on a falling external edge while the frame pulse is seen low.
    always_comb align = align_en && step_fall && fp_seen;

    // Advance, wrap or realign the frame position.
    always_ff @(posedge clk) begin
        if (!rst_n)    pos <= '0;
        else if (align) pos <= '0;
        else if (step)  pos <= (pos == POS_LAST) ? '0 : pos + 1'b1;
    end

    // R4: the last position wraps to frame start.
    assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && pos == POS_LAST) |=> (pos == '0));
    // R8: an alignment request lands on frame start.
    assert_align_R8: assert property (@(posedge clk) disable iff (!rst_n)
        align |=> (pos == '0));
    // R6: without a step the position holds.
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(pos));
endmodule

// File: rtl/tdm_out_stage.sv
`timescale 1ns/1ps
// Module: tdm_out_stage
// Decodes the frame position into the clock and frame-pulse lines and applies the
// output enables. Bit 0 of the position is the 4.096 MHz clock, bit 1 the 2.048 MHz
// clock. The frame pulse is low over the last and the first position of the frame.
// Assumes the frame holds at least four half periods.
module tdm_out_stage
    import tdm_pkg::*;
#(
    parameter int HALVES_PER_FRAME = 1024,
    parameter int CW               = 10
) (
    input  logic          [CW-1:0] pos,
    input  logic                   en_c4,
    input  logic                   en_c2,
    output tdm_lines_t             lines
);
    localparam logic [CW-1:0] POS_LAST = CW'(HALVES_PER_FRAME - 1);

    // Decode the lines and drive the disabled ones low.
    always_comb begin
        lines.c4   = pos[0];
        lines.c4_n = en_c4 & ~pos[0];
        lines.c2_a = en_c2 & pos[1];
        lines.c2_b = en_c2 & ~pos[1];
        lines.fp_n = !((pos == POS_LAST) || (pos == '0));
    end
endmodule

// File: rtl/tdm_clkgen.sv
`timescale 1ns/1ps
// Module: tdm_clkgen (top)
// TDM backplane clock and frame generator. It steps either on corrected master ticks
// (MASTER_PER_C4 ticks per 4.096 MHz period) or on an external 4.096 MHz clock, and
// it can realign to an external frame pulse. Tri-state is modelled by *_en/*_oe flags.
// Assumes MASTER_PER_C4 is even and C4_PER_FRAME is at least 2.
module tdm_clkgen
    import tdm_pkg::*;
#(
    parameter int MASTER_PER_C4 = 4,
    parameter int C4_PER_FRAME  = 512,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic master_tick,
    input  logic int_src,
    input  logic fp_dir_out,
    input  logic ext_clk4,
    input  logic ext_fp_n,
    input  logic en_c4,
    input  logic en_c2,
    output logic c4,
    output logic c4_n,
    output logic c4_n_en,
    output logic c2_a,
    output logic c2_b,
    output logic c2_en,
    output logic fp_n,
    output logic fp_oe
);
    localparam int TICKS_PER_HALF   = MASTER_PER_C4 / 2;
    localparam int HALVES_PER_FRAME = 2 * C4_PER_FRAME;
    localparam int CW               = idx_width(HALVES_PER_FRAME);

    logic          step;
    logic          step_fall;
    logic          fp_seen;
    logic [CW-1:0] pos;
    tdm_lines_t    lines;

    tdm_edge_src #(
        .TICKS_PER_HALF(TICKS_PER_HALF),
        .SYNC_STAGES   (SYNC_STAGES)
    ) u_src (
        .clk        (clk),
        .rst_n      (rst_n),
        .int_src    (int_src),
        .master_tick(master_tick),
        .ext_clk4   (ext_clk4),
        .ext_fp_n   (ext_fp_n),
        .step       (step),
        .step_fall  (step_fall),
        .fp_seen    (fp_seen)
    );

    tdm_frame_ctr #(
        .HALVES_PER_FRAME(HALVES_PER_FRAME),
        .CW              (CW)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .step_fall(step_fall),
        .fp_seen  (fp_seen),
        .align_en (!fp_dir_out),
        .pos      (pos)
    );

    tdm_out_stage #(
        .HALVES_PER_FRAME(HALVES_PER_FRAME),
        .CW              (CW)
    ) u_out (
        .pos  (pos),
        .en_c4(en_c4),
        .en_c2(en_c2),
        .lines(lines)
    );

    // Map the lines and the drive flags to the ports.
    always_comb begin
        c4      = lines.c4;
        c4_n    = lines.c4_n;
        c2_a    = lines.c2_a;
        c2_b    = lines.c2_b;
        fp_n    = lines.fp_n;
        c4_n_en = en_c4;
        c2_en   = en_c2;
        fp_oe   = fp_dir_out;
    end

    // R4: with master ticks as the source, the frame pulse lasts more than one cycle.
    assert_fp_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (int_src && $fell(fp_n)) |=> !fp_n);
    // R9: with master ticks as the source and no tick, external inputs move nothing.
    assert_ext_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (int_src && $past(int_src) && !$past(master_tick)) |-> $stable(fp_n));
endmodule

// File: tb/tb_tdm_clkgen.sv
`timescale 1ns/1ps
// Bench for tdm_clkgen: a position model that steps from the requirements, random
// ticks and external edges, and directed cases for alignment and frame wrap.
module tb_tdm_clkgen;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic master_tick = 1'b0;
    logic int_src = 1'b1;
    logic fp_dir_out = 1'b1;
    logic ext_clk4 = 1'b0;
    logic ext_fp_n = 1'b1;
    logic en_c4 = 1'b1;
    logic en_c2 = 1'b1;
    logic c4, c4_n, c4_n_en, c2_a, c2_b, c2_en, fp_n, fp_oe;

    int checks = 0;
    int fails  = 0;
    int mh = 0;          // model frame position
    int mh_prev = 0;
    int tick_acc = 0;
    bit pend = 1'b0;
    logic prev_c4 = 1'b0;
    logic prev_c2a = 1'b0;
    bit directed_coincide = 1'b0;

    tdm_clkgen dut (
        .clk(clk), .rst_n(rst_n), .master_tick(master_tick), .int_src(int_src),
        .fp_dir_out(fp_dir_out), .ext_clk4(ext_clk4), .ext_fp_n(ext_fp_n),
        .en_c4(en_c4), .en_c2(en_c2), .c4(c4), .c4_n(c4_n), .c4_n_en(c4_n_en),
        .c2_a(c2_a), .c2_b(c2_b), .c2_en(c2_en), .fp_n(fp_n), .fp_oe(fp_oe)
    );

    always #4 clk = ~clk;

    function automatic int exp_fp(input int h);
        return (h == 1023 || h == 0) ? 0 : 1;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tc4, input string tfp);
        int b0 = mh % 2;
        int b1 = (mh / 2) % 2;
        chk(tc4, "c4", int'(c4), b0);
        chk("R3", "c2_a", int'(c2_a), en_c2 ? b1 : 0);
        chk("R3", "c2_b", int'(c2_b), en_c2 ? 1 - b1 : 0);
        chk("R10", "c4_n", int'(c4_n), en_c4 ? 1 - b0 : 0);
        chk("R10", "c4_n_en", int'(c4_n_en), int'(en_c4));
        chk("R10", "c2_en", int'(c2_en), int'(en_c2));
        chk(tfp, "fp_n", int'(fp_n), exp_fp(mh));
        chk("R7", "fp_oe", int'(fp_oe), int'(fp_dir_out));
        // R5: at the step into frame start, c4 and c2_a fall while the pulse is low
        if (mh == 0 && mh_prev == 1023) begin
            chk("R5", "c4 fall in window", int'({prev_c4, c4, fp_n}), 4);
            if (en_c2) chk("R5", "c2_a fall in window", int'({prev_c2a, c2_a}), 2);
        end
        prev_c4  = c4;
        prev_c2a = c2_a;
        mh_prev  = mh;
    endtask

    task automatic do_reset(input bit isrc, input bit fdir);
        rst_n = 1'b0; int_src = isrc; fp_dir_out = fdir;
        ext_clk4 = 1'b0; ext_fp_n = 1'b1; master_tick = 1'b0;
        en_c4 = 1'b1; en_c2 = 1'b1;
        repeat (4) @(negedge clk);
        mh = 0; mh_prev = 0; tick_acc = 0; pend = 1'b0;
        check_all("R1", "R1");          // R1 during reset
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1", "R1");          // R1 right after release
    endtask

    // One half period of the external clock, then a check just before the next one.
    task automatic ext_half(input bit fpl, input string tfp);
        bit lvl = ~ext_clk4;
        ext_clk4 = lvl;
        ext_fp_n = ~fpl;
        if (lvl == 1'b0 && fpl && !int_src && !fp_dir_out) mh = 0;
        else mh = (mh + 1) % 1024;
        for (int k = 0; k < $urandom_range(4, 7); k++) begin
            master_tick = ($urandom_range(0, 1) == 1);   // R6: ticks are ignored
            @(negedge clk);
        end
        check_all("R6", tfp);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL R2 watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240917));

        // Phase 1: master ticks as the source, external lines toggled as noise (R9).
        do_reset(1'b1, 1'b0);
        for (int i = 0; i < 7000; i++) begin
            if (pend) begin
                tick_acc++;
                if (tick_acc == 2) begin tick_acc = 0; mh = (mh + 1) % 1024; end
            end
            check_all("R2", "R4/R9");
            master_tick = ($urandom_range(0, 2) != 0);
            pend = master_tick;
            ext_clk4 = ($urandom_range(0, 1) == 1);
            ext_fp_n = ($urandom_range(0, 3) != 0);
            if (i % 500 == 499) begin
                en_c4 = ($urandom_range(0, 1) == 1);
                en_c2 = ($urandom_range(0, 2) != 0);
            end
            @(negedge clk);
        end
        master_tick = 1'b0;

        // Phase 2: external clock source with the frame pulse as an input (R6, R8).
        do_reset(1'b0, 1'b0);
        for (int i = 0; i < 1100; i++) begin
            bit fpl = 1'b0;
            // Alignment coinciding with the natural wrap at a falling edge
            if (mh == 1023 && ext_clk4 == 1'b1 && !directed_coincide) begin
                fpl = 1'b1;
                directed_coincide = 1'b1;
            end
            ext_half(fpl, "R8");
        end
        chk("R8", "wrap coincidence exercised", int'(directed_coincide), 1);
        for (int i = 0; i < 600; i++) begin
            bit fpl = ($urandom_range(0, 29) == 0);
            if (i == 11) fpl = 1'b1;     // directed mid-frame alignment (either edge)
            ext_half(fpl, "R8");
        end

        // Phase 3: external clock, frame pulse as an output: alignment ignored (R9).
        fp_dir_out = 1'b1;
        for (int i = 0; i < 300; i++) begin
            ext_half($urandom_range(0, 2) == 0, "R9");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule